// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds an alarm setting for a real-time clock. It compares that setting with the clock's live calendar counters once per seconds update. The setting has six fields: seconds, minutes, hours, day of week, day of month and month. Each field has its own include bit. A field whose include bit is clear accepts any counter value. When every included field equals its counter at a seconds update, a sticky alarm flag is set. While the alarm interrupt enable is also set, an interrupt line is driven high. Software clears the flag by writing zero to it.

The time counters are inputs to the block. They come from the calendar logic beside it, as BCD values, with a one-cycle strobe at each seconds update. Software reaches the six alarm fields and one control byte through a simple synchronous write port and a combinational read port. The control byte carries the flag and the interrupt enable.

The sequencer has two named states:
- `ST_WAIT`: idle between seconds updates.
- `ST_CHECK`: the cycle after a strobe, in which the captured counters are judged.

The transitions are:
- WAIT→CHECK and CHECK→CHECK when `sec_tick` is high.
- CHECK→WAIT and WAIT→WAIT when it is low.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, every alarm field reads 0x00, the control byte reads 0x00 and `alarm_irq` is low.
- R2: Addresses 0 to 5 hold the alarm fields for seconds, minutes, hours, day of week, day of month and month (month coded 1 to 12 in BCD). Each is 8 bits wide: bit 7 is the include bit and bits 6:0 are the BCD value. A written byte reads back unchanged.
- R3: When `sec_tick` is sampled high at a clock edge, the six counters are captured at that edge. If at least one field is included and every included field equals its captured counter, the flag reads 1 after the next clock edge.
- R4: A field with bit 7 clear matches any counter value.
- R5: When no field has bit 7 set, the flag is never set.
- R6: If any included field differs from its counter, that update leaves the flag unchanged.
- R7: Counter values that match but arrive without `sec_tick` do not set the flag.
- R8: Address 6 is the control byte, with the flag in bit 0 and the interrupt enable in bit 3 (other bits read 0). Writing bit 0 as 0 clears the flag. Writing bit 0 as 1 leaves the flag as it was.
- R9: `alarm_irq` is high exactly while both the flag and the interrupt enable are 1, and it stays high until one of them is cleared.
- R10: If a match and a software clear of the flag fall on the same edge, the flag is set.
- R11: Writes to address 7 change nothing, and reads of address 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe at each seconds update |
| cur_sec | input | 7 | Live seconds counter, BCD |
| cur_min | input | 7 | Live minutes counter, BCD |
| cur_hour | input | 7 | Live hours counter, BCD |
| cur_wday | input | 7 | Live day-of-week counter |
| cur_mday | input | 7 | Live day-of-month counter, BCD |
| cur_mon | input | 7 | Live month counter, BCD 1 to 12 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
On every cycle, the assertions check three things:
- the flag rises only in the cycle after a strobe;
- an update with no included field never sets the flag, and a qualifying match always sets it, even against a clear;
- a software clear with no match drops the flag.

Only the bench's scenarios can show the rest. These are:
- that the right counter is paired with the right alarm address;
- that excluded fields really act as match-all for arbitrary values;
- that month 12 and other edge values compare correctly;
- that writes to the spare address and writes of 1 to the flag leave the visible state alone.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
    localparam int ALM_FIELD_W   = 7;
    localparam int ALM_NUM_FIELDS = 6;
    localparam int ALM_ADDR_W    = 3;
    localparam int ALM_CTRL_ADDR = 6;
    localparam int ALM_FLAG_BIT  = 0;
    localparam int ALM_AIE_BIT   = 3;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_CHECK = 1'b1
    } alm_state_e;
endpackage

// File: rtl/alarm_field_match.sv
`timescale 1ns/1ps
module alarm_field_match #(
    parameter int FIELD_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snap_en,
    input  logic [FIELD_W:0]   alarm_byte,
    input  logic [FIELD_W-1:0] cur_val,
    output logic               field_en,
    output logic               field_hit
);
    logic [FIELD_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (snap_en)
            snap_q <= cur_val;
    end

    assign field_en  = alarm_byte[FIELD_W];
    assign field_hit = !field_en || (snap_q == alarm_byte[FIELD_W-1:0]);
endmodule

// File: rtl/alarm_regs.sv
`timescale 1ns/1ps
module alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = ALM_NUM_FIELDS,
    parameter int FIELD_W    = ALM_FIELD_W,
    parameter int ADDR_W     = ALM_ADDR_W,
    parameter int CTRL_ADDR  = ALM_CTRL_ADDR
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [FIELD_W:0]                   wr_data,
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic                               flag,
    output logic [NUM_FIELDS-1:0][FIELD_W:0]   alarm_q,
    output logic                               aie,
    output logic                               clr_req,
    output logic [FIELD_W:0]                   rd_data
);
    localparam int REG_W = FIELD_W + 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == CTRL_A);
    assign clr_req = ctrl_wr && !wr_data[ALM_FLAG_BIT];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                alarm_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            aie <= 1'b0;
        else if (ctrl_wr)
            aie <= wr_data[ALM_AIE_BIT];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = alarm_q[i];
        end
        if (rd_addr == CTRL_A) begin
            rd_data                = '0;
            rd_data[ALM_AIE_BIT]   = aie;
            rd_data[ALM_FLAG_BIT]  = flag;
        end
    end

    // R2
    field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (alarm_q[0] == $past(wr_data)));

    logic unused_w;
    assign unused_w = (REG_W == 0);
endmodule

// File: rtl/alarm_seq.sv
`timescale 1ns/1ps
module alarm_seq
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_FIELDS = ALM_NUM_FIELDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sec_tick,
    input  logic [NUM_FIELDS-1:0] field_en,
    input  logic [NUM_FIELDS-1:0] field_hit,
    input  logic                  clr_req,
    input  logic                  aie,
    output logic                  snap_en,
    output logic                  flag,
    output logic                  irq
);
    alm_state_e state_q, state_d;
    logic       fire;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_WAIT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  state_d = sec_tick ? ST_CHECK : ST_WAIT;
            ST_CHECK: state_d = sec_tick ? ST_CHECK : ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    assign snap_en = sec_tick;
    assign fire    = (state_q == ST_CHECK) && (|field_en) && (&field_hit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (fire)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assign irq = flag && aie;

    // R3 R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(state_q == ST_CHECK));

    // R7
    check_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |-> $past(sec_tick));

    // R5
    none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_en == '0 && !flag) |=> !flag);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && field_en != '0 && field_hit == '1) |=> flag);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && state_q == ST_WAIT) |=> !flag);
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int FIELD_W = ALM_FIELD_W,
    parameter int ADDR_W  = ALM_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_wday,
    input  logic [FIELD_W-1:0] cur_mday,
    input  logic [FIELD_W-1:0] cur_mon,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [FIELD_W:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [FIELD_W:0]   rd_data,
    output logic               alarm_irq
);
    localparam int NF = ALM_NUM_FIELDS;

    logic [NF-1:0][FIELD_W-1:0] cur_vals;
    logic [NF-1:0][FIELD_W:0]   alarm_q;
    logic [NF-1:0]              field_en, field_hit;
    logic                       aie, clr_req, flag, snap_en;

    assign cur_vals[0] = cur_sec;
    assign cur_vals[1] = cur_min;
    assign cur_vals[2] = cur_hour;
    assign cur_vals[3] = cur_wday;
    assign cur_vals[4] = cur_mday;
    assign cur_vals[5] = cur_mon;

    alarm_regs #(
        .NUM_FIELDS (NF),
        .FIELD_W    (FIELD_W),
        .ADDR_W     (ADDR_W),
        .CTRL_ADDR  (ALM_CTRL_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flag    (flag),
        .alarm_q (alarm_q),
        .aie     (aie),
        .clr_req (clr_req),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        alarm_field_match #(.FIELD_W(FIELD_W)) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .snap_en    (snap_en),
            .alarm_byte (alarm_q[g]),
            .cur_val    (cur_vals[g]),
            .field_en   (field_en[g]),
            .field_hit  (field_hit[g])
        );
    end

    alarm_seq #(.NUM_FIELDS(NF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .field_en  (field_en),
        .field_hit (field_hit),
        .clr_req   (clr_req),
        .aie       (aie),
        .snap_en   (snap_en),
        .flag      (flag),
        .irq       (alarm_irq)
    );

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && !clr_req && !(wr_en && wr_addr == ADDR_W'(ALM_CTRL_ADDR))) |=> alarm_irq);
endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] cur [6];
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       alarm_irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_alm [6];
    logic       exp_aie = 1'b0;
    logic       exp_flag = 1'b0;

    always #10 clk = ~clk;

    rtc_alarm_match uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
        .cur_wday(cur[3]), .cur_mday(cur[4]), .cur_mon(cur[5]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .alarm_irq(alarm_irq)
    );

    function automatic logic [6:0] to_bcd(int n);
        return 7'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic model_match();
        logic any = 1'b0;
        logic all = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (exp_alm[i][7]) begin
                any = 1'b1;
                if (exp_alm[i][6:0] != cur[i]) all = 1'b0;
            end
        end
        return any && all;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (a < 3'd6) exp_alm[a] = d;
        else if (a == 3'd6) begin
            exp_aie = d[3];
            if (!d[0]) exp_flag = 1'b0;
        end
    endtask

    task automatic tick();
        logic m;
        m = model_match();
        sec_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        sec_tick = 1'b0;
        @(posedge clk); @(negedge clk);
        if (m) exp_flag = 1'b1;
    endtask

    task automatic check_ctrl(string req);
        logic [7:0] d;
        rd(3'd6, d);
        chk(req, d, {4'b0, exp_aie, 2'b0, exp_flag});
        chk("R9", {7'b0, alarm_irq}, {7'b0, exp_flag & exp_aie});
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lim [6] = '{60, 60, 24, 7, 31, 12};
        int base [6] = '{0, 0, 0, 0, 1, 1};
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) begin cur[i] = '0; exp_alm[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            chk("R1", d, 8'h00);
        end
        chk("R1", {7'b0, alarm_irq}, 8'h00);

        // R2 readback, every field
        for (int i = 0; i < 6; i++) begin
            wr(3'(i), 8'h80 | 8'(to_bcd(base[i] + i)));
            rd(3'(i), d);
            chk("R2", d, exp_alm[i]);
        end

        // R2 month 12 match with only month included
        for (int i = 0; i < 6; i++) wr(3'(i), 8'h00);
        wr(3'd5, 8'h80 | 8'h12);
        wr(3'd6, 8'h08);
        cur[5] = 7'h12; cur[0] = 7'h37;
        tick();
        check_ctrl("R2");

        // R8 writing 1 to flag keeps it; writing 0 clears
        wr(3'd6, 8'h09);
        check_ctrl("R8");
        wr(3'd6, 8'h08);
        check_ctrl("R8");

        // R6 month mismatch
        cur[5] = 7'h11;
        tick();
        check_ctrl("R6");

        // R7 matching counters without strobe
        cur[5] = 7'h12;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_ctrl("R7");

        // R5 nothing included
        wr(3'd5, 8'h12);
        tick();
        check_ctrl("R5");

        // R4 excluded fields accept anything
        wr(3'd0, 8'h80 | 8'h45);
        cur[0] = 7'h45; cur[1] = 7'h59; cur[2] = 7'h23;
        tick();
        check_ctrl("R4");

        // R10 match and clear on the same edge
        wr(3'd6, 8'h08);
        check_ctrl("R8");
        sec_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        sec_tick = 1'b0;
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h08;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        exp_flag = 1'b1;
        check_ctrl("R10");

        // R11 spare address
        wr(3'd7, 8'hFF);
        rd(3'd7, d);
        chk("R11", d, 8'h00);
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d);
            chk("R11", d, exp_alm[i]);
        end
        check_ctrl("R11");

        // R3 random configurations
        for (int it = 0; it < 60; it++) begin
            logic [5:0] mask;
            mask = 6'($urandom);
            if (it % 10 == 0) mask = '0;
            wr(3'd6, {4'b0, 1'($urandom), 3'b000});
            for (int i = 0; i < 6; i++) begin
                logic [6:0] v;
                v = to_bcd(base[i] + int'($urandom % lim[i]));
                wr(3'(i), {mask[i], v});
                if ($urandom % 4 != 0) cur[i] = v;
                else cur[i] = to_bcd(base[i] + int'($urandom % lim[i]));
            end
            tick();
            check_ctrl("R3");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule